// File: doc/BRIEF.md
# Multi-Mode Video Sync Output Generator

This block sits at the output end of a video pipeline, just ahead of a digital transmitter or a video DAC. It takes one pixel per clock (three colour channels and a data-enable) together with vertical and horizontal sync pulses, both active high. From these it builds the sync signals that the display link needs, in one of four encodings chosen by a two-bit mode input. The choices are: separate syncs, composite sync, sync carried on the green channel, and separate syncs with horizontal pulses removed during vertical sync.

Every output leaves through exactly one register stage. The syncs, the pixel channels and the data-enable therefore arrive together, one clock after the inputs that produced them. The video stream cannot be stalled. A new pixel is accepted on every clock and there is no back-pressure, so no valid/ready handshake exists. Mode and polarity are plain static controls, but they are sampled on every clock like the data.

Top module: `vsync_out_gen`

## Requirements
- R1: While `rst_n` is low, every output (`vs_out`, `hs_out`, `sog_n_out`, `de_out`, and all colour bits) is 0.
- R2: `r_out`, `g_out`, `b_out` and `de_out` equal `r_in`, `g_in`, `b_in` and `de_in` from the previous clock edge, one cycle of latency.
- R3: In mode 0 (`sync_mode` = 2'b00, separate), `vs_out` is the previous cycle's `vs_in` and `hs_out` is the previous cycle's `hs_in`. Each is inverted when its polarity input is 0. `sog_n_out` is 0.
- R4: In mode 1 (2'b01, composite), `hs_out` is the previous cycle's `vs_in | hs_in`, unaffected by polarity inputs. `vs_out` and `sog_n_out` are 0.
- R5: In mode 2 (2'b10, sync on green), `sog_n_out` is the previous cycle's `~(vs_in | hs_in)`, so it is low during any sync. `vs_out` and `hs_out` are 0.
- R6: In mode 3 (2'b11, separate blocked), `vs_out` and `sog_n_out` behave as in mode 0. `hs_out` carries `hs_in & ~vs_in` from the previous cycle, with `hs_pol` applied, so a horizontal pulse inside vertical sync gives the inactive level.
- R7: `vs_pol` and `hs_pol` act independently. A value of 1 gives an active-high output and 0 gives active-low.
- R8: A change of `sync_mode` or of a polarity input shows on the sync outputs after the same single clock edge as the syncs it is applied to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 2 | Sync encoding select (0 separate, 1 composite, 2 on green, 3 separate blocked) |
| vs_pol | input | 1 | Vertical output polarity, 1 = active high |
| hs_pol | input | 1 | Horizontal output polarity, 1 = active high |
| vs_in | input | 1 | Vertical sync, active high |
| hs_in | input | 1 | Horizontal sync, active high |
| de_in | input | 1 | Pixel data-enable |
| r_in | input | DW | Red channel |
| g_in | input | DW | Green channel |
| b_in | input | DW | Blue channel |
| vs_out | output | 1 | Vertical sync output |
| hs_out | output | 1 | Horizontal or composite sync output |
| sog_n_out | output | 1 | Sync-on-green level, active low |
| de_out | output | 1 | Registered data-enable |
| r_out | output | DW | Registered red |
| g_out | output | DW | Registered green |
| b_out | output | DW | Registered blue |

## Verification
The assertions compare each output with the inputs of the previous cycle. They do this only when the previous cycle was also out of reset, so they assume every input, including `sync_mode` and both polarities, is steady across each rising edge. The stimulus changes all inputs only on the falling clock edge and samples shortly after the rising edge. The sweeps cover every vertical/horizontal pairing under each mode and polarity, including vertical and horizontal sync active together, which is the case that tells mode 3 apart from mode 0.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

  typedef enum logic [1:0] {
    SM_SEPARATE    = 2'd0,
    SM_COMPOSITE   = 2'd1,
    SM_ON_GREEN    = 2'd2,
    SM_SEP_BLOCKED = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic vs;
    logic hs;
    logic sog_n;
  } sync_bus_t;

  localparam sync_bus_t SYNC_IDLE = '{vs: 1'b0, hs: 1'b0, sog_n: 1'b0};

endpackage

// File: rtl/vsync_encoder.sv
module vsync_encoder
  import vsync_pkg::*;
(
  input  logic       vs,
  input  logic       hs,
  input  logic [1:0] mode,
  input  logic       vs_pol,
  input  logic       hs_pol,
  output sync_bus_t  enc
);

  logic composite;
  logic hs_gated;
  logic vs_polar;

  // composite sync is any active pulse; blocked horizontal drops pulses in vsync
  assign composite = vs | hs;
  assign hs_gated  = hs & ~vs;
  assign vs_polar  = vs_pol ? vs : ~vs;

  always_comb begin
    enc = SYNC_IDLE;
    unique case (sync_mode_e'(mode))
      SM_SEPARATE: begin
        enc.vs = vs_polar;
        enc.hs = hs_pol ? hs : ~hs;
      end
      SM_COMPOSITE: begin
        enc.hs = composite;
      end
      SM_ON_GREEN: begin
        enc.sog_n = ~composite;
      end
      SM_SEP_BLOCKED: begin
        enc.vs = vs_polar;
        enc.hs = hs_pol ? hs_gated : ~hs_gated;
      end
      default: enc = SYNC_IDLE;
    endcase
  end

endmodule

// File: rtl/vsync_sync_reg.sv
module vsync_sync_reg
  import vsync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sync_bus_t d,
  output sync_bus_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= SYNC_IDLE;
    else        q <= d;
  end

endmodule

// File: rtl/vsync_pixel_stage.sv
module vsync_pixel_stage #(
  parameter int DW  = 10,
  parameter int NCH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                de_d,
  input  logic [NCH*DW-1:0]   pix_d,
  output logic                de_q,
  output logic [NCH*DW-1:0]   pix_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) de_q <= 1'b0;
    else        de_q <= de_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) pix_q[c*DW +: DW] <= '0;
      else        pix_q[c*DW +: DW] <= pix_d[c*DW +: DW];
    end
  end

endmodule

// File: rtl/vsync_out_gen.sv
module vsync_out_gen
  import vsync_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sync_mode,
  input  logic          vs_pol,
  input  logic          hs_pol,
  input  logic          vs_in,
  input  logic          hs_in,
  input  logic          de_in,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] g_in,
  input  logic [DW-1:0] b_in,
  output logic          vs_out,
  output logic          hs_out,
  output logic          sog_n_out,
  output logic          de_out,
  output logic [DW-1:0] r_out,
  output logic [DW-1:0] g_out,
  output logic [DW-1:0] b_out
);

  localparam int NCH = 3;
  localparam int PW  = NCH * DW;

  sync_bus_t      enc_d;
  sync_bus_t      enc_q;
  logic [PW-1:0]  pix_q;

  vsync_encoder u_enc (
    .vs     (vs_in),
    .hs     (hs_in),
    .mode   (sync_mode),
    .vs_pol (vs_pol),
    .hs_pol (hs_pol),
    .enc    (enc_d)
  );

  vsync_sync_reg u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (enc_d),
    .q     (enc_q)
  );

  vsync_pixel_stage #(.DW(DW), .NCH(NCH)) u_pix (
    .clk   (clk),
    .rst_n (rst_n),
    .de_d  (de_in),
    .pix_d ({r_in, g_in, b_in}),
    .de_q  (de_out),
    .pix_q (pix_q)
  );

  assign vs_out    = enc_q.vs;
  assign hs_out    = enc_q.hs;
  assign sog_n_out = enc_q.sog_n;
  assign r_out     = pix_q[2*DW +: DW];
  assign g_out     = pix_q[DW +: DW];
  assign b_out     = pix_q[0 +: DW];

endmodule

// File: rtl/vsync_out_gen_chk.sv
module vsync_out_gen_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sync_mode,
  input logic          vs_pol,
  input logic          hs_pol,
  input logic          vs_in,
  input logic          hs_in,
  input logic          de_in,
  input logic [DW-1:0] r_in,
  input logic [DW-1:0] g_in,
  input logic [DW-1:0] b_in,
  input logic          vs_out,
  input logic          hs_out,
  input logic          sog_n_out,
  input logic          de_out,
  input logic [DW-1:0] r_out,
  input logic [DW-1:0] g_out,
  input logic [DW-1:0] b_out
);

  // R1: reset clears everything one edge later
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> (!vs_out && !hs_out && !sog_n_out && !de_out &&
                       r_out == '0 && g_out == '0 && b_out == '0));

  // R2: pixel path latency
  a_r2_pixel_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (de_out == $past(de_in) && r_out == $past(r_in) &&
                      g_out == $past(g_in) && b_out == $past(b_in)));

  // R3 R7 R8: separate mode
  a_r3_separate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_mode) == 2'd0) |->
      (vs_out == ($past(vs_pol) ? $past(vs_in) : !$past(vs_in)) &&
       hs_out == ($past(hs_pol) ? $past(hs_in) : !$past(hs_in)) && !sog_n_out));

  // R4: composite mode
  a_r4_composite: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_mode) == 2'd1) |->
      (hs_out == ($past(vs_in) || $past(hs_in)) && !vs_out && !sog_n_out));

  // R5: sync on green
  a_r5_on_green: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_mode) == 2'd2) |->
      (sog_n_out == !($past(vs_in) || $past(hs_in)) && !vs_out && !hs_out));

  // R6: blocked horizontal
  a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_mode) == 2'd3 && $past(vs_in)) |->
      (hs_out == !$past(hs_pol) && !sog_n_out));

  // at most one of composite-style outputs asserted in the shared modes
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_mode) != 2'd0 && $past(sync_mode) != 2'd3) |->
      $onehot0({vs_out, hs_out, sog_n_out}));

endmodule

bind vsync_out_gen vsync_out_gen_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_mode (sync_mode),
  .vs_pol    (vs_pol),
  .hs_pol    (hs_pol),
  .vs_in     (vs_in),
  .hs_in     (hs_in),
  .de_in     (de_in),
  .r_in      (r_in),
  .g_in      (g_in),
  .b_in      (b_in),
  .vs_out    (vs_out),
  .hs_out    (hs_out),
  .sog_n_out (sog_n_out),
  .de_out    (de_out),
  .r_out     (r_out),
  .g_out     (g_out),
  .b_out     (b_out)
);

// File: tb/vsync_out_gen_bench.sv
module vsync_out_gen_bench;

  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sync_mode = 2'd0;
  logic          vs_pol = 1'b1;
  logic          hs_pol = 1'b1;
  logic          vs_in = 1'b0;
  logic          hs_in = 1'b0;
  logic          de_in = 1'b0;
  logic [DW-1:0] r_in = '0;
  logic [DW-1:0] g_in = '0;
  logic [DW-1:0] b_in = '0;
  logic          vs_out, hs_out, sog_n_out, de_out;
  logic [DW-1:0] r_out, g_out, b_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vsync_out_gen #(.DW(DW)) u_vsync_out_gen (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .vs_pol(vs_pol),
    .hs_pol(hs_pol), .vs_in(vs_in), .hs_in(hs_in), .de_in(de_in),
    .r_in(r_in), .g_in(g_in), .b_in(b_in), .vs_out(vs_out), .hs_out(hs_out),
    .sog_n_out(sog_n_out), .de_out(de_out), .r_out(r_out), .g_out(g_out),
    .b_out(b_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // expected {vs, hs, sog_n} from the requirements
  function automatic logic [2:0] expect_sync(input logic [1:0] m, input logic v,
                                             input logic h, input logic vp,
                                             input logic hp);
    logic hb;
    hb = h & ~v;
    case (m)
      2'd0:    return {vp ? v : ~v, hp ? h : ~h, 1'b0};
      2'd1:    return {1'b0, v | h, 1'b0};
      2'd2:    return {1'b0, 1'b0, ~(v | h)};
      default: return {vp ? v : ~v, hp ? hb : ~hb, 1'b0};
    endcase
  endfunction

  // drive on falling edge, sample just after the next rising edge
  task automatic step_sync(input string req, input logic [1:0] m, input logic v,
                           input logic h, input logic vp, input logic hp);
    @(negedge clk);
    sync_mode = m; vs_in = v; hs_in = h; vs_pol = vp; hs_pol = hp;
    @(posedge clk);
    #2;
    check(req, "sync {vs,hs,sog_n}", {29'd0, vs_out, hs_out, sog_n_out},
          {29'd0, expect_sync(m, v, h, vp, hp)});
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0; de_in = 1'b1; r_in = 10'h3FF; g_in = 10'h155; b_in = 10'h2AA;
    vs_in = 1'b1; hs_in = 1'b1; sync_mode = 2'd2;
    @(posedge clk); #2;
    check("R1", "outputs in reset",
          {2'd0, vs_out, hs_out, sog_n_out, de_out, r_out, g_out, b_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1; de_in = 1'b0; vs_in = 1'b0; hs_in = 1'b0; sync_mode = 2'd0;
  endtask

  task automatic test_pixels();
    logic [DW-1:0] pat [4];
    pat[0] = 10'h000; pat[1] = 10'h3FF; pat[2] = 10'h2A5; pat[3] = 10'h15A;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      r_in = pat[i]; g_in = ~pat[i]; b_in = pat[(i + 1) % 4]; de_in = i[0];
      @(negedge clk);
      check("R2", "red", {22'd0, r_out}, {22'd0, pat[i]});
      check("R2", "green", {22'd0, g_out}, {22'd0, ~pat[i]});
      check("R2", "blue", {22'd0, b_out}, {22'd0, pat[(i + 1) % 4]});
      check("R2", "de", {31'd0, de_out}, {31'd0, i[0]});
    end
  endtask

  task automatic test_separate();
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        step_sync(p == 0 ? "R3" : "R7", 2'd0, s[1], s[0], p[1], p[0]);
  endtask

  task automatic test_composite();
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        step_sync("R4", 2'd1, s[1], s[0], p[1], p[0]);
  endtask

  task automatic test_on_green();
    for (int s = 0; s < 4; s++) step_sync("R5", 2'd2, s[1], s[0], 1'b0, 1'b1);
  endtask

  task automatic test_blocked();
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        step_sync("R6", 2'd3, s[1], s[0], p[1], p[0]);
  endtask

  task automatic test_switch();
    // both syncs active; mode changes with them, old value must not leak
    step_sync("R8", 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    step_sync("R8", 2'd2, 1'b1, 1'b1, 1'b1, 1'b1);
    step_sync("R8", 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    step_sync("R8", 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    step_sync("R8", 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_pixels();
    test_separate();
    test_composite();
    test_on_green();
    test_blocked();
    test_switch();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule